// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Deframer

This block sits behind a serial receiver and turns a raw stream of bytes into framed packet bytes. The sender wraps each packet between a start marker and an end marker. It hides any payload byte that collides with a marker behind one of two escape codes. It may insert a channel field, and it may pad the stream with idle fill at any point. The deframer discards idle fill and everything that arrives before a start marker. It undoes the escaping, checks that the channel number is the accepted one, and presents each payload byte with start-of-packet and end-of-packet flags.

The end marker is sent one payload byte early. It announces that the next ordinary data byte is the final one, and that byte completes the packet. A start marker that shows up inside a packet abandons the partial packet. The bytes already delivered are then left without an end flag, and the next payload byte carries a fresh start flag. A consumer that sees a start flag before an end flag therefore drops what it had collected. Malformed marker sequences produce a one-cycle error pulse, and the parser then goes back to hunting for a start marker.

Every accepted byte yields its result one clock later. Each input byte gives at most one payload beat or one error pulse, never both.

Top module: `dfr_deframer`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_valid, out_sop, out_eop and out_err are all low.
- R2: Before the first start marker (0x7A), every byte is discarded and produces neither a beat nor an error. The same holds after an error or after a completed packet.
- R3: Idle bytes (0x4A) are dropped anywhere. This includes between an escape code and the byte it guards, and between a channel marker and its channel number. The pending state is left untouched.
- R4: The non-idle byte that follows an escape code (0x7D or 0x4D) is delivered XOR 0x20.
- R5: The first non-idle byte after a channel marker (0x7C) is the channel number and is never delivered. A value equal to CHAN_ID (default 0) is accepted. Any other value, including a marker code, raises out_err and the parser hunts again.
- R6: After an end marker (0x7B), the next data byte is delivered with out_eop high. The parser then hunts for a new start marker.
- R7: The first data byte delivered after a start marker carries out_sop high. Later bytes of the same packet carry it low.
- R8: A start marker inside a packet discards the partial packet: the bytes already delivered never get out_eop, and the next data byte carries out_sop.
- R9: An end or channel marker that directly follows an escape code or an end marker raises out_err. So does an escape code directly after an escape code. In each case the parser hunts again.
- R10: Each input byte is reflected on the outputs exactly one clock after it is accepted. A cycle with in_valid low produces no beat and no error.
- R11: out_err and out_valid are never high together, and out_eop and out_sop are only high with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Raw byte from the serial receiver |
| out_valid | output | 1 | A payload byte is presented |
| out_sop | output | 1 | Presented byte is the first of its packet |
| out_eop | output | 1 | Presented byte is the last of its packet |
| out_byte | output | 8 | Unescaped payload byte |
| out_err | output | 1 | One-cycle pulse on a protocol violation |

## Verification
The hardest situations to reach are the pending states combined with idle fill. Examples are an escape or a channel marker whose follower arrives only after several idle bytes, and a start marker that lands while a channel number is still awaited. Directed sequences place idle bytes inside each of these windows and walk through every illegal marker pair. A long random stream is then weighted heavily toward marker, escape and idle codes and compared byte by byte against a reference parser in the bench, so that these pending states keep recurring alongside restarts and errors.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_START = 8'h7A;
    localparam logic [BYTE_W-1:0] CODE_END   = 8'h7B;
    localparam logic [BYTE_W-1:0] CODE_CHAN  = 8'h7C;
    localparam logic [BYTE_W-1:0] CODE_PESC  = 8'h7D;
    localparam logic [BYTE_W-1:0] CODE_IDLE  = 8'h4A;
    localparam logic [BYTE_W-1:0] CODE_XESC  = 8'h4D;
    localparam logic [BYTE_W-1:0] ESC_FLIP   = 8'h20;

    typedef enum logic [2:0] {
        K_FILL,
        K_START,
        K_END,
        K_CHAN,
        K_ESC,
        K_DATA
    } kind_e;

    // parser context
    typedef struct packed {
        logic in_pkt;     // a start marker has been seen
        logic esc;        // escape pending
        logic tail;       // end marker seen, next data byte is last
        logic chan_wait;  // channel number awaited
        logic first;      // next data byte opens the packet
    } ctx_t;

    // one output beat
    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [BYTE_W-1:0] data;
        logic              err;
    } beat_t;

    localparam ctx_t CTX_HUNT  = '{in_pkt: 1'b0, esc: 1'b0, tail: 1'b0, chan_wait: 1'b0, first: 1'b0};
    localparam ctx_t CTX_FRESH = '{in_pkt: 1'b1, esc: 1'b0, tail: 1'b0, chan_wait: 1'b0, first: 1'b1};

    function automatic kind_e classify(input logic [BYTE_W-1:0] b);
        kind_e k;
        unique case (b)
            CODE_IDLE:            k = K_FILL;
            CODE_START:           k = K_START;
            CODE_END:             k = K_END;
            CODE_CHAN:            k = K_CHAN;
            CODE_PESC, CODE_XESC: k = K_ESC;
            default:              k = K_DATA;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dfr_classify.sv
module dfr_classify
    import dfr_pkg::*;
(
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              act,
    output kind_e             kind
);
    always_comb begin
        kind = classify(in_byte);
        act  = in_valid && (kind != K_FILL);
    end
endmodule

// File: rtl/dfr_parser.sv
module dfr_parser
    import dfr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHAN_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  kind_e             kind,
    input  logic [BYTE_W-1:0] in_byte,
    output beat_t             beat
);
    ctx_t ctx_q, ctx_d;

    always_comb begin
        ctx_d = ctx_q;
        beat  = '0;
        if (act) begin
            if (!ctx_q.in_pkt) begin
                if (kind == K_START) ctx_d = CTX_FRESH;
            end else if (ctx_q.chan_wait) begin
                if (in_byte != CHAN_ID) begin
                    beat.err = 1'b1;
                    ctx_d    = CTX_HUNT;
                end else begin
                    ctx_d.chan_wait = 1'b0;
                end
            end else begin
                unique case (kind)
                    K_START: ctx_d = CTX_FRESH;
                    K_END: begin
                        if (ctx_q.esc || ctx_q.tail) begin
                            beat.err = 1'b1;
                            ctx_d    = CTX_HUNT;
                        end else begin
                            ctx_d.tail = 1'b1;
                        end
                    end
                    K_CHAN: begin
                        if (ctx_q.esc || ctx_q.tail) begin
                            beat.err = 1'b1;
                            ctx_d    = CTX_HUNT;
                        end else begin
                            ctx_d.chan_wait = 1'b1;
                        end
                    end
                    K_ESC: begin
                        if (ctx_q.esc) begin
                            beat.err = 1'b1;
                            ctx_d    = CTX_HUNT;
                        end else begin
                            ctx_d.esc = 1'b1;
                        end
                    end
                    K_DATA: begin
                        beat.valid  = 1'b1;
                        beat.sop    = ctx_q.first;
                        beat.eop    = ctx_q.tail;
                        beat.data   = ctx_q.esc ? (in_byte ^ ESC_FLIP) : in_byte;
                        ctx_d.first = 1'b0;
                        ctx_d.esc   = 1'b0;
                        if (ctx_q.tail) ctx_d = CTX_HUNT;
                    end
                    default: ctx_d = ctx_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= CTX_HUNT;
        else     ctx_q <= ctx_d;
    end
endmodule

// File: rtl/dfr_outreg.sv
module dfr_outreg
    import dfr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat_d,
    output beat_t beat_q
);
    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end
endmodule

// File: rtl/dfr_deframer.sv
module dfr_deframer
    import dfr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHAN_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_err
);
    logic  act;
    kind_e kind;
    beat_t beat_c, beat_r;

    dfr_classify u_cls (
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .act      (act),
        .kind     (kind)
    );

    dfr_parser #(.CHAN_ID(CHAN_ID)) u_prs (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .kind    (kind),
        .in_byte (in_byte),
        .beat    (beat_c)
    );

    dfr_outreg u_out (
        .clk    (clk),
        .rst    (rst),
        .beat_d (beat_c),
        .beat_q (beat_r)
    );

    assign out_valid = beat_r.valid;
    assign out_sop   = beat_r.sop;
    assign out_eop   = beat_r.eop;
    assign out_byte  = beat_r.data;
    assign out_err   = beat_r.err;
endmodule

// File: rtl/dfr_checker.sv
module dfr_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic       out_sop,
    input logic       out_eop,
    input logic       out_err
);
    logic opened;

    always_ff @(posedge clk) begin
        if (rst) opened <= 1'b0;
        else if (out_err || (out_valid && out_eop)) opened <= 1'b0;
        else if (out_valid) opened <= 1'b1;
    end

    // R11
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_err && out_valid));

    // R11
    flag_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (out_eop || out_sop) |-> out_valid);

    // R10
    quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_err));

    // R3
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == 8'h4A) |=> (!out_valid && !out_err));

    // R7
    open_sop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !opened) |-> out_sop);

    // R8
    start_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == 8'h7A) |=> !out_valid);
endmodule

bind dfr_deframer dfr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err)
);

// File: tb/sim_dfr_deframer.sv
`timescale 1ns/1ps
module sim_dfr_deframer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_sop, out_eop, out_err;
    logic [7:0] out_byte;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dfr_deframer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_byte(out_byte), .out_err(out_err)
    );

    // reference parser state
    bit m_pkt, m_esc, m_tail, m_chw, m_first;
    bit e_v, e_sop, e_eop, e_err;
    logic [7:0] e_b;
    string tag;

    function automatic void hunt();
        m_pkt = 0; m_esc = 0; m_tail = 0; m_chw = 0; m_first = 0;
    endfunction

    function automatic void model(input bit v, input logic [7:0] b);
        e_v = 0; e_sop = 0; e_eop = 0; e_err = 0; e_b = 8'h00;
        tag = "R10";
        if (!v) return;
        if (b == 8'h4A) begin tag = "R3"; return; end
        if (!m_pkt) begin
            tag = "R2";
            if (b == 8'h7A) begin hunt(); m_pkt = 1; m_first = 1; end
            return;
        end
        if (m_chw) begin
            tag = "R5";
            if (b != 8'h00) begin e_err = 1; hunt(); end
            else m_chw = 0;
            return;
        end
        if (b == 8'h7A) begin
            tag = "R8"; hunt(); m_pkt = 1; m_first = 1;
        end else if (b == 8'h7B || b == 8'h7C) begin
            tag = "R9";
            if (m_esc || m_tail) begin e_err = 1; hunt(); end
            else if (b == 8'h7B) m_tail = 1;
            else m_chw = 1;
        end else if (b == 8'h7D || b == 8'h4D) begin
            tag = "R9";
            if (m_esc) begin e_err = 1; hunt(); end
            else m_esc = 1;
        end else begin
            e_v = 1; e_sop = m_first; e_eop = m_tail;
            e_b = m_esc ? (b ^ 8'h20) : b;
            tag = m_tail ? "R6" : (m_esc ? "R4" : (m_first ? "R7" : "R10"));
            m_first = 0; m_esc = 0;
            if (m_tail) hunt();
        end
    endfunction

    task automatic step(input bit v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v; in_byte = b;
        model(v, b);
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== e_v || out_err !== e_err || out_sop !== e_sop ||
            out_eop !== e_eop || (e_v && out_byte !== e_b)) begin
            failures++;
            $display("FAIL %s in=%0b/%02h got v=%0b s=%0b e=%0b b=%02h err=%0b exp v=%0b s=%0b e=%0b b=%02h err=%0b",
                     tag, v, b, out_valid, out_sop, out_eop, out_byte, out_err,
                     e_v, e_sop, e_eop, e_b, e_err);
        end
    endtask

    task automatic send(input logic [7:0] b);
        step(1'b1, b);
    endtask

    task automatic check_quiet(input string t);
        checks++;
        if (out_valid !== 1'b0 || out_sop !== 1'b0 || out_eop !== 1'b0 || out_err !== 1'b0) begin
            failures++;
            $display("FAIL %s reset outputs v=%0b s=%0b e=%0b err=%0b exp all 0",
                     t, out_valid, out_sop, out_eop, out_err);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        hunt();
        repeat (3) @(posedge clk);
        #1 check_quiet("R1");
        @(negedge clk) rst = 1'b0;
        @(posedge clk) #1 check_quiet("R1");

        // R2: garbage before start
        send(8'h11); send(8'h7B); send(8'h4D); send(8'h7C); send(8'h05);
        // R7 R4 R6: start, escaped payload, end before last byte
        send(8'h7A); send(8'h4A); send(8'h33); send(8'h7D); send(8'h5A);
        send(8'h4D); send(8'h4A); send(8'h6A); send(8'h7B); send(8'h4A); send(8'h44);
        // R2 after completion
        send(8'h55);
        // R5 channel zero with idle between, R3
        send(8'h7A); send(8'h7C); send(8'h4A); send(8'h00); send(8'h21);
        send(8'h7B); send(8'h7D); send(8'h5D);
        // R5 nonzero channel
        send(8'h7A); send(8'h7C); send(8'h03); send(8'h22);
        // R5 start marker as channel number
        send(8'h7A); send(8'h7C); send(8'h7A); send(8'h23);
        // R9 end after escape
        send(8'h7A); send(8'h7D); send(8'h7B); send(8'h24);
        // R9 channel after end
        send(8'h7A); send(8'h7B); send(8'h7C);
        // R9 end after end
        send(8'h7A); send(8'h7B); send(8'h7B);
        // R9 escape after escape
        send(8'h7A); send(8'h4D); send(8'h7D); send(8'h25);
        // R9 channel after escape
        send(8'h7A); send(8'h4D); send(8'h7C);
        // R8 restart mid-packet
        send(8'h7A); send(8'h31); send(8'h32); send(8'h7A); send(8'h41);
        send(8'h7B); send(8'h42);
        // R10 gaps
        step(1'b0, 8'h7A); send(8'h7A); step(1'b0, 8'h50); send(8'h51); send(8'h7B); send(8'h52);

        // random stream weighted to codes
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] b;
            bit v;
            int r;
            r = $urandom % 16;
            v = 1'b1;
            case (r)
                0, 1: b = 8'h7A;
                2:    b = 8'h7B;
                3:    b = 8'h7C;
                4:    b = 8'h7D;
                5:    b = 8'h4D;
                6, 7: b = 8'h4A;
                8:    b = 8'h00;
                9:    begin b = 8'h00; v = 1'b0; end
                default: b = 8'($urandom);
            endcase
            step(v, b);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule